// File: doc/BRIEF.md
# Per-Pipe Buffer-Empty / Oversize Interrupt Status Register

This block holds one interrupt flag for each of a group of data pipes in a USB device controller. The event that raises a flag depends on the direction of its pipe. On a pipe that sends data to the host, the flag rises when the pipe's transmit buffer becomes empty. On a pipe that receives data, the flag rises when a packet ends with a byte count above the pipe's maximum packet size. That oversize event also forces the pipe's two-bit handshake response code to STALL.

Software reads the flags and clears them by writing zero to their bit positions. A clear is refused while the internal clock enable is low. A separate enable register masks each flag into one combined interrupt line. The block also holds the per-pipe response code and maximum-packet-size registers, so that the oversize comparison and the forced STALL sit beside the flag they affect. Register reads are combinational, and writes take effect at the next clock edge.

Top module: `usbint_status_top`

## Requirements
- R1: After reset every flag, every enable bit and every response code is 0, and every maximum-packet-size register is 64. Pipe i (counting from 0) owns status bit 3+i at address 0, and the same bit position in the enable register at address 1. All other status and enable bits read 0.
- R2: On a pipe whose direction input is 1 (transmit), a 0-to-1 change of its buffer-empty input sets its flag at the next clock edge.
- R3: A buffer-empty input that stays at 1 does not set the flag again after software has cleared it.
- R4: On a pipe whose direction input is 0 (receive), an end-of-packet strobe with a byte count greater than the pipe's maximum packet size sets the flag. A byte count equal to or below that size does not.
- R5: An oversize event sets the pipe's response code to 2'b10 (STALL). The code then holds until software writes the response register. Clearing the flag does not change it.
- R6: A write to address 0 clears each flag whose bit is written 0. Writing 1 to a flag bit leaves that bit unchanged.
- R7: While clk_en is 0, writes to address 0 clear nothing.
- R8: When a set event and a clearing write reach the same flag in one cycle, the flag ends up set.
- R9: irq is 1 exactly when some flag is 1 and its enable bit is 1.
- R10: A buffer-empty edge on a receive pipe, or an oversize packet end on a transmit pipe, has no effect on the flag or on the response code.
- R11: The response code of pipe i is read and written in bits [1:0] at address 4+i. Its maximum packet size is read and written in bits [10:0] at address 8+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Internal clock enable. Software clears are refused when this is 0 |
| pipe_dir_in | input | 4 | Per-pipe direction: 1 = transmit to host, 0 = receive |
| buf_empty | input | 4 | Per-pipe transmit buffer empty level |
| rx_end | input | 4 | Per-pipe end-of-received-packet strobe |
| rx_count | input | 48 | Per-pipe received byte count, 12 bits each, pipe i at [12i+11:12i] |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| pid_out | output | 8 | Per-pipe response code, pipe i at [2i+1:2i] |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a set event that lands in the same cycle as a software clear of the same bit. Both the cause and the clear write have to arrive together, while clk_en is high. The directed part of the bench lines up a buffer-empty edge with a write of zero. The random part then keeps this case coming up: it toggles buffer-empty levels, fires end-of-packet strobes with byte counts within two of the current maximum packet size, and drops clk_en in about one cycle in eight. That last part also produces clears while the clock enable is low, and oversize events that land on a response code software has just written.

// File: rtl/usbint_pkg.sv
package usbint_pkg;

   localparam int unsigned STAT_ADDR = 0;
   localparam int unsigned ENA_ADDR  = 1;

   typedef enum logic [1:0] {
      RSP_NAK   = 2'b00,
      RSP_ACK   = 2'b01,
      RSP_STALL = 2'b10,
      RSP_HALT  = 2'b11
   } rsp_code_e;

endpackage

// File: rtl/usbint_evt.sv
module usbint_evt #(
   parameter int CNT_W = 12,
   parameter int MPS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dir_in,
   input  logic             buf_empty,
   input  logic             rx_end,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [MPS_W-1:0] mps,
   output logic             empty_hit,
   output logic             size_hit
);

   logic empty_q;

   // previous level of buffer-empty; reset high so a buffer that is already
   // empty when reset ends is not treated as a new event
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) empty_q <= 1'b1;
      else        empty_q <= buf_empty;
   end

   assign empty_hit = dir_in && buf_empty && !empty_q;
   assign size_hit  = !dir_in && rx_end && (rx_count > CNT_W'(mps));

   // an empty edge cannot repeat on the following cycle (level must drop first)
   assert_edge_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      empty_hit |=> !empty_hit);

endmodule

// File: rtl/usbint_cfg.sv
module usbint_cfg
   import usbint_pkg::*;
#(
   parameter int             MPS_W   = 11,
   parameter logic [MPS_W-1:0] MPS_RST = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pid_we,
   input  logic             mps_we,
   input  logic [1:0]       wdata_pid,
   input  logic [MPS_W-1:0] wdata_mps,
   input  logic             size_hit,
   output logic [1:0]       pid,
   output logic [MPS_W-1:0] mps
);

   logic [1:0]       pid_q;
   logic [MPS_W-1:0] mps_q;

   // hardware STALL outranks a software write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pid_q <= RSP_NAK;
      else if (size_hit) pid_q <= RSP_STALL;
      else if (pid_we)   pid_q <= wdata_pid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mps_q <= MPS_RST;
      else if (mps_we) mps_q <= wdata_mps;
   end

   assign pid = pid_q;
   assign mps = mps_q;

   assert_stall_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(size_hit)) |-> (pid_q == RSP_STALL));

   assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(pid_q[1]) && !$past(pid_we)) |-> pid_q[1]);

endmodule

// File: rtl/usbint_flag.sv
module usbint_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_en,
   input  logic set_evt,
   input  logic clr_wr,
   output logic flag
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  flag_q <= 1'b0;
      else if (set_evt)            flag_q <= 1'b1;
      else if (clr_wr && clk_en)   flag_q <= 1'b0;
   end

   assign flag = flag_q;

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(set_evt)) |-> flag_q);

   assert_gated_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(flag_q) && !$past(clk_en)) |-> flag_q);

   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(clr_wr) && $past(clk_en) && !$past(set_evt)) |-> !flag_q);

   assert_no_soft_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(flag_q) && !$past(set_evt)) |-> !flag_q);

endmodule

// File: rtl/usbint_status_top.sv
module usbint_status_top
   import usbint_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 4,
   parameter int NUM_PIPES = 4,
   parameter int PIPE_LO   = 3,
   parameter int MPS_W     = 11,
   parameter int CNT_W     = 12,
   parameter int MPS_RST   = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clk_en,
   input  logic [NUM_PIPES-1:0]       pipe_dir_in,
   input  logic [NUM_PIPES-1:0]       buf_empty,
   input  logic [NUM_PIPES-1:0]       rx_end,
   input  logic [NUM_PIPES*CNT_W-1:0] rx_count,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic                       reg_wr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   output logic [2*NUM_PIPES-1:0]     pid_out,
   output logic                       irq
);

   localparam int NP       = NUM_PIPES;
   localparam int PID_BASE = 4;
   localparam int MPS_BASE = PID_BASE + ((NP > 4) ? NP : 4);
   localparam int ADDR_TOP = MPS_BASE + NP;

   // elaboration-time parameter checks
   if (PIPE_LO + NP > DATA_W) begin : g_chk_bits
      $error("pipe flags do not fit in the data word");
   end
   if (MPS_W > DATA_W || MPS_W < 1) begin : g_chk_mps
      $error("max-packet-size width out of range");
   end
   if (CNT_W < MPS_W) begin : g_chk_cnt
      $error("byte count narrower than max packet size");
   end
   if (ADDR_TOP > (1 << ADDR_W)) begin : g_chk_addr
      $error("register map exceeds address space");
   end
   if (MPS_RST >= (1 << MPS_W)) begin : g_chk_rst
      $error("max-packet-size reset value too wide");
   end

   logic [NP-1:0]    flags;
   logic [NP-1:0]    ena_q;
   logic [NP-1:0]    e_hit;
   logic [NP-1:0]    s_hit;
   logic [1:0]       pid_arr [NP];
   logic [MPS_W-1:0] mps_arr [NP];
   logic             wr_stat;
   logic             wr_ena;
   logic [DATA_W-1:0] stat_vec;
   logic [DATA_W-1:0] ena_vec;
   logic             unused_wdata;

   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));
   assign wr_ena  = reg_wr && (reg_addr == ADDR_W'(ENA_ADDR));
   assign unused_wdata = ^reg_wdata;

   for (genvar i = 0; i < NP; i++) begin : g_pipe
      usbint_evt #(
         .CNT_W (CNT_W),
         .MPS_W (MPS_W)
      ) u_evt (
         .clk       (clk),
         .rst_n     (rst_n),
         .dir_in    (pipe_dir_in[i]),
         .buf_empty (buf_empty[i]),
         .rx_end    (rx_end[i]),
         .rx_count  (rx_count[i*CNT_W +: CNT_W]),
         .mps       (mps_arr[i]),
         .empty_hit (e_hit[i]),
         .size_hit  (s_hit[i])
      );

      usbint_cfg #(
         .MPS_W   (MPS_W),
         .MPS_RST (MPS_W'(MPS_RST))
      ) u_cfg (
         .clk       (clk),
         .rst_n     (rst_n),
         .pid_we    (reg_wr && (reg_addr == ADDR_W'(PID_BASE + i))),
         .mps_we    (reg_wr && (reg_addr == ADDR_W'(MPS_BASE + i))),
         .wdata_pid (reg_wdata[1:0]),
         .wdata_mps (reg_wdata[MPS_W-1:0]),
         .size_hit  (s_hit[i]),
         .pid       (pid_arr[i]),
         .mps       (mps_arr[i])
      );

      usbint_flag u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .clk_en  (clk_en),
         .set_evt (e_hit[i] || s_hit[i]),
         .clr_wr  (wr_stat && !reg_wdata[PIPE_LO + i]),
         .flag    (flags[i])
      );

      assign pid_out[2*i +: 2] = pid_arr[i];

      // direction gates the cause: a receive pipe never sees an empty edge,
      // a transmit pipe never sees an oversize
      assert_dir_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !(e_hit[i] && s_hit[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ena_q <= '0;
      else if (wr_ena) ena_q <= reg_wdata[PIPE_LO +: NP];
   end

   always_comb begin
      stat_vec = DATA_W'(flags) << PIPE_LO;
      ena_vec  = DATA_W'(ena_q) << PIPE_LO;
   end

   assign irq = |(flags & ena_q);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(STAT_ADDR)) reg_rdata = stat_vec;
      if (reg_addr == ADDR_W'(ENA_ADDR))  reg_rdata = ena_vec;
      for (int k = 0; k < NP; k++) begin
         if (reg_addr == ADDR_W'(PID_BASE + k)) reg_rdata = DATA_W'(pid_arr[k]);
         if (reg_addr == ADDR_W'(MPS_BASE + k)) reg_rdata = DATA_W'(mps_arr[k]);
      end
   end

   assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0 || ena_q == '0) |-> !irq);

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (flags == '0 && ena_q == '0));

endmodule

// File: tb/sim_usbint_status_top.sv
module sim_usbint_status_top;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int DW = 16;
   localparam int AW = 4;
   localparam int LO = 3;
   localparam int MW = 11;
   localparam int CW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clk_en = 1'b1;
   logic [NP-1:0] dir = 4'b0011;
   logic [NP-1:0] be = '0;
   logic [NP-1:0] rxe = '0;
   logic [NP*CW-1:0] cnt = '0;
   logic [AW-1:0] addr = '0;
   logic wr = 1'b0;
   logic [DW-1:0] wdata = '0;
   wire  [DW-1:0] rdata;
   wire  [2*NP-1:0] pid;
   wire  irq;

   int nvec = 0;
   int nfail = 0;
   bit done = 1'b0;

   // reference state
   logic [NP-1:0] m_flag = '0;
   logic [NP-1:0] m_en = '0;
   logic [NP-1:0] m_beq = '1;
   logic [1:0]    m_pid [NP];
   logic [MW-1:0] m_mps [NP];

   always #(CLK_PERIOD/2) clk = ~clk;

   usbint_status_top u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .clk_en      (clk_en),
      .pipe_dir_in (dir),
      .buf_empty   (be),
      .rx_end      (rxe),
      .rx_count    (cnt),
      .reg_addr    (addr),
      .reg_wr      (wr),
      .reg_wdata   (wdata),
      .reg_rdata   (rdata),
      .pid_out     (pid),
      .irq         (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] stat_exp(input logic [NP-1:0] f);
      return DW'(f) << LO;
   endfunction

   // predict next state from current inputs, advance one edge, compare
   task automatic tick(input string tag);
      logic [NP-1:0] nf;
      logic [NP-1:0] ne;
      logic [1:0]    npd [NP];
      logic [MW-1:0] nm  [NP];
      for (int i = 0; i < NP; i++) begin
         logic er;
         logic ov;
         logic clr;
         er  = dir[i] & be[i] & ~m_beq[i];
         ov  = ~dir[i] & rxe[i] & (cnt[i*CW +: CW] > {1'b0, m_mps[i]});
         clr = wr && (addr == AW'(0)) && !wdata[LO+i] && clk_en;
         nf[i]  = (er | ov) ? 1'b1 : (clr ? 1'b0 : m_flag[i]);
         npd[i] = ov ? 2'b10 : ((wr && addr == AW'(4+i)) ? wdata[1:0] : m_pid[i]);
         nm[i]  = (wr && addr == AW'(8+i)) ? wdata[MW-1:0] : m_mps[i];
      end
      ne = (wr && addr == AW'(1)) ? wdata[LO +: NP] : m_en;
      @(posedge clk);
      m_flag = nf;
      m_en   = ne;
      m_beq  = be;
      for (int i = 0; i < NP; i++) begin
         m_pid[i] = npd[i];
         m_mps[i] = nm[i];
      end
      #1;
      chk({tag, " R9 irq"}, 32'(irq), 32'(|(m_flag & m_en)));
      for (int i = 0; i < NP; i++)
         chk({tag, " R5 pid"}, 32'(pid[2*i +: 2]), 32'(m_pid[i]));
      wr = 1'b0;
      addr = '0;
      #1;
      chk({tag, " R1 status"}, 32'(rdata), 32'(stat_exp(m_flag)));
      @(negedge clk);
      rxe = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      wr = 1'b0;
      addr = a;
      #1;
      chk(tag, 32'(rdata), 32'(exp));
   endtask

   task automatic wreg(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      wr = 1'b1;
      addr = a;
      wdata = d;
      tick(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         nfail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed));
      for (int i = 0; i < NP; i++) begin
         m_pid[i] = 2'b00;
         m_mps[i] = MW'(64);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(AW'(0), 16'h0000, "R1 status after reset");
      rd(AW'(1), 16'h0000, "R1 enable after reset");
      rd(AW'(4), 16'h0000, "R1 pid after reset");
      rd(AW'(9), 16'd64,   "R1 mps after reset");
      chk("R1 irq after reset", 32'(irq), 32'd0);

      // enable every pipe
      wreg(AW'(1), 16'hFFFF, "R9 enable all");
      rd(AW'(1), 16'h0078, "R1 enable readback");

      // R2 transmit pipe 0 empty edge
      be[0] = 1'b1;
      tick("R2 empty edge");
      rd(AW'(0), 16'h0008, "R2 flag pipe0");
      chk("R9 irq on", 32'(irq), 32'd1);

      // R3 clear while still empty, no re-trigger
      wreg(AW'(0), 16'h0000, "R3 clear");
      tick("R3 hold empty");
      rd(AW'(0), 16'h0000, "R3 no retrigger");

      // R10 wrong-direction causes
      be[2] = 1'b1;
      rxe[0] = 1'b1;
      cnt[0*CW +: CW] = 12'd1000;
      tick("R10 cross direction");
      rd(AW'(0), 16'h0000, "R10 no flag");
      chk("R10 pid0 untouched", 32'(pid[1:0]), 32'd0);

      // R4 equal size, then oversize
      rxe[2] = 1'b1;
      cnt[2*CW +: CW] = 12'd64;
      tick("R4 equal");
      rd(AW'(0), 16'h0000, "R4 equal no flag");
      rxe[2] = 1'b1;
      cnt[2*CW +: CW] = 12'd65;
      tick("R4 over");
      rd(AW'(0), 16'h0020, "R4 oversize flag");
      chk("R5 stall forced", 32'(pid[5:4]), 32'd2);

      // R5 clear does not restore, software rewrite does
      wreg(AW'(0), 16'h0000, "R5 clear");
      chk("R5 stall kept", 32'(pid[5:4]), 32'd2);
      wreg(AW'(6), 16'h0001, "R5 rewrite");
      chk("R5 rewritten", 32'(pid[5:4]), 32'd1);

      // R7 clear refused while clock enable low
      wreg(AW'(11), 16'd8, "R11 mps write");
      rxe[3] = 1'b1;
      cnt[3*CW +: CW] = 12'd9;
      tick("R4 small mps");
      rd(AW'(0), 16'h0040, "R4 pipe3 flag");
      clk_en = 1'b0;
      wreg(AW'(0), 16'h0000, "R7 gated clear");
      rd(AW'(0), 16'h0040, "R7 flag kept");
      clk_en = 1'b1;

      // R6 writing ones has no effect
      wreg(AW'(0), 16'hFFFF, "R6 write ones");
      rd(AW'(0), 16'h0040, "R6 ones");
      wreg(AW'(0), 16'h0040, "R6 keep bit");
      rd(AW'(0), 16'h0040, "R6 one keeps");

      // R8 set and clear in the same cycle
      be[1] = 1'b1;
      wreg(AW'(0), 16'h0000, "R8 collide");
      rd(AW'(0), 16'h0010, "R8 set wins");

      // R11 readback
      rd(AW'(6), 16'h0001, "R11 pid readback");
      rd(AW'(11), 16'd8, "R11 mps readback");
      rd(AW'(8), 16'd64, "R11 mps default");

      // R9 mask
      wreg(AW'(1), 16'h0000, "R9 disable");
      chk("R9 masked irq", 32'(irq), 32'd0);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         wr = 1'b0;
         clk_en = ($urandom_range(0, 7) != 0);
         if ($urandom_range(0, 63) == 0) dir = NP'($urandom);
         be  = be ^ (NP'($urandom) & NP'($urandom));
         rxe = NP'($urandom) & NP'($urandom);
         for (int i = 0; i < NP; i++) begin
            if ($urandom_range(0, 9) == 0)
               cnt[i*CW +: CW] = CW'($urandom);
            else
               cnt[i*CW +: CW] = CW'(m_mps[i]) + CW'($urandom_range(0, 4)) - CW'(2);
         end
         if ($urandom_range(0, 3) == 0) begin
            wr = 1'b1;
            case ($urandom_range(0, 3))
               0: begin addr = AW'(0); wdata = DW'($urandom); end
               1: begin addr = AW'(1); wdata = DW'($urandom); end
               2: begin addr = AW'(4 + $urandom_range(0, 3)); wdata = DW'($urandom); end
               default: begin addr = AW'(8 + $urandom_range(0, 3)); wdata = DW'($urandom_range(0, 200)); end
            endcase
         end
         tick("R8 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule